// File: doc/BRIEF.md
# Multichannel Serial Audio Output Formatter

This block turns six stereo mix accumulators into six serial audio data lines and generates the three clocks that frame them: a bit clock, a left/right clock and a word clock. The bit clock toggles on every pulse of a free-running enable. The left/right clock and all data move on its falling edge. The left/right half length is programmable. Inside each half, a word window runs from a programmable start position to a programmable end position. The word clock is high during the window, and the data lines carry the sample MSB first during it.

Each accumulator is 23 bits wide, with three guard bits above a 20-bit signed sample. It is saturated to the 20-bit range before it is serialized. All six channels are sampled together at the start of the word window in the high half of the left/right clock. The right sample goes out in that half. The left sample from the same capture goes out in the following low half.

The window positions are taken on the rising edge of the left/right clock, and the half length is taken on its falling edge. Software may therefore rewrite them at any time without tearing a frame. Three disable inputs stop the bit clock, the left/right clock or the word output separately.

Top module: `serial_audio_fmt`

## Requirements
- R1: Each 23-bit signed accumulator is saturated to -524288..524287 before serialization: values above the range send 0x7FFFF and values below it send 0x80000.
- R2: With the bit clock enabled, `bclk_o` toggles on every clock cycle in which `bclk_tick` is high. `lrclk_o`, `wclk_o` and `sdata_o` change only on a 1-to-0 step of `bclk_o`, except for the forced low of R10.
- R3: Each left/right half lasts exactly `lr_len` bit-clock falling edges, counting the edge that toggles `lrclk_o`. `lr_len` is loaded on the falling edge of `lrclk_o`. After reset the length is 32 until the first such load.
- R4: `word_start` and `word_end` are captured on the rising edge of `lrclk_o` and apply to that half and the following low half. Changes at any other time do not alter the half in progress.
- R5: The position counter restarts at 0 on the bit-clock falling edge that toggles `lrclk_o`, and it counts up by one on each later falling edge.
- R6: `wclk_o` goes high on the falling edge at position `word_start` and low on the falling edge at position `word_end`. It is therefore high for `word_end - word_start` edges. When the two are equal, no pulse appears.
- R7: During the window each `sdata_o` line carries sample bit 19 at position `word_start`, then bit 18, and so on, one bit per falling edge. At most 20 bits are sent, and only at positions below `word_end`.
- R8: All twelve samples are captured at position `word_start` while `lrclk_o` is high. The right samples are sent in that high half. The left samples from the same capture are sent in the next low half.
- R9: `sdata_o` is zero whenever `wclk_o` is low and after all 20 bits of the word have been sent.
- R10: While `dis_bit` is high, `bclk_o` is held low and no falling edge occurs. While `dis_lr` is high, `lrclk_o` holds its level. While `dis_word` is high, `wclk_o` and `sdata_o` are held low.
- R11: Reset drives all clocks and data lines low and clears the sample latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_tick | input | 1 | Bit-clock half-period enable |
| dis_lr | input | 1 | Stop the left/right clock |
| dis_word | input | 1 | Stop the word clock and data output |
| dis_bit | input | 1 | Stop the bit clock |
| left_acc | input | 6*23 | Left accumulators, channel c at bits [c*23 +: 23], signed |
| right_acc | input | 6*23 | Right accumulators, same packing |
| word_start | input | 7 | Window start position |
| word_end | input | 7 | Window end position |
| lr_len | input | 7 | Left/right half length in bit-clock periods |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Left/right clock, high selects right |
| wclk_o | output | 1 | Word clock |
| sdata_o | output | 6 | Serial data, one line per channel |

## Verification
A wrong position counter or a wrong half-length register shows within one half. In that case the word-clock pulse starts at the wrong position, or the half length measured between `lrclk_o` transitions is wrong. A wrong window capture or a wrong sample latch shows when that word is rebuilt from the serial lines, at most one frame later. Saturation faults appear as a wrong top bit in the reconstructed word. A bit-counter fault appears either as nonzero data after the twentieth bit or as data outside the window.

// File: rtl/serial_audio_fmt.sv
module serial_audio_fmt #(
  parameter int NCH    = 6,
  parameter int ACC_W  = 23,
  parameter int OUT_W  = 20,
  parameter int CNT_W  = 7,
  parameter int LR_RST = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bclk_tick,
  input  logic                   dis_lr,
  input  logic                   dis_word,
  input  logic                   dis_bit,
  input  logic [NCH*ACC_W-1:0]   left_acc,
  input  logic [NCH*ACC_W-1:0]   right_acc,
  input  logic [CNT_W-1:0]       word_start,
  input  logic [CNT_W-1:0]       word_end,
  input  logic [CNT_W-1:0]       lr_len,
  output logic                   bclk_o,
  output logic                   lrclk_o,
  output logic                   wclk_o,
  output logic [NCH-1:0]         sdata_o
);

  localparam int BIT_W = $clog2(OUT_W + 1);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  function automatic logic [OUT_W-1:0] sat(input logic signed [ACC_W-1:0] v);
    if (v > SAT_HI) return SAT_HI[OUT_W-1:0];
    if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
    return v[OUT_W-1:0];
  endfunction

  logic [CNT_W-1:0] lr_cnt, lr_len_cur, wcnt, ws_cur, we_cur;
  logic [BIT_W-1:0] bits_left;
  logic             side_q;
  logic [NCH*OUT_W-1:0] lat_l, lat_r, nxt_l, nxt_r;
  logic [NCH-1:0]   sdata_d;

  wire fall    = bclk_tick && !dis_bit && bclk_o;
  wire lr_tog  = fall && !dis_lr &&
                 (({1'b0, lr_cnt} + 1'b1) >= {1'b0, lr_len_cur});
  wire lr_new  = lr_tog ? !lrclk_o : lrclk_o;
  wire lr_rise = lr_tog && !lrclk_o;

  wire [CNT_W-1:0] ws_eff = lr_rise ? word_start : ws_cur;
  wire [CNT_W-1:0] we_eff = lr_rise ? word_end   : we_cur;
  wire [CNT_W-1:0] wc_eff = lr_tog ? '0 : wcnt;

  wire w_start = (wc_eff == ws_eff);
  wire w_end   = (wc_eff == we_eff);
  wire take    = w_start && lr_new;
  wire [BIT_W-1:0] bits_eff = w_start ? BIT_W'(OUT_W) : bits_left;
  wire shift   = (bits_eff != '0) && (wc_eff < we_eff);
  wire side_eff = w_start ? lr_new : side_q;
  wire [BIT_W-1:0] idx = bits_eff - 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [OUT_W-1:0] wl, wr;
    assign nxt_l[c*OUT_W +: OUT_W] = take ? sat(left_acc[c*ACC_W +: ACC_W])
                                          : lat_l[c*OUT_W +: OUT_W];
    assign nxt_r[c*OUT_W +: OUT_W] = take ? sat(right_acc[c*ACC_W +: ACC_W])
                                          : lat_r[c*OUT_W +: OUT_W];
    assign wl = nxt_l[c*OUT_W +: OUT_W];
    assign wr = nxt_r[c*OUT_W +: OUT_W];
    assign sdata_d[c] = shift && (side_eff ? wr[idx] : wl[idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_o     <= 1'b0;
      lrclk_o    <= 1'b0;
      wclk_o     <= 1'b0;
      sdata_o    <= '0;
      lr_cnt     <= '0;
      lr_len_cur <= CNT_W'(LR_RST);
      wcnt       <= '0;
      ws_cur     <= '0;
      we_cur     <= '0;
      bits_left  <= '0;
      side_q     <= 1'b0;
      lat_l      <= '0;
      lat_r      <= '0;
    end else begin
      if (dis_bit)        bclk_o <= 1'b0;
      else if (bclk_tick) bclk_o <= !bclk_o;

      if (fall && !dis_lr) begin
        if (lr_tog) begin
          lrclk_o <= !lrclk_o;
          lr_cnt  <= '0;
          if (lrclk_o) lr_len_cur <= lr_len;
          else begin
            ws_cur <= word_start;
            we_cur <= word_end;
          end
        end else begin
          lr_cnt <= lr_cnt + 1'b1;
        end
      end

      if (fall && !dis_word) begin
        wcnt      <= (&wc_eff) ? wc_eff : wc_eff + 1'b1;
        lat_l     <= nxt_l;
        lat_r     <= nxt_r;
        side_q    <= side_eff;
        bits_left <= w_end ? '0 : (shift ? idx : bits_eff);
        wclk_o    <= w_end ? 1'b0 : (w_start ? 1'b1 : wclk_o);
        sdata_o   <= sdata_d;
      end

      if (dis_word) begin
        wclk_o    <= 1'b0;
        sdata_o   <= '0;
        bits_left <= '0;
      end
    end
  end

  p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk_o) |-> $past(fall));
  p_wclk_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wclk_o) |-> $past(fall && !dis_word));
  p_cnt_in_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_cnt == '0) || (lr_cnt < lr_len_cur));
  p_bits_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bits_left <= BIT_W'(OUT_W));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wclk_o |-> (sdata_o == '0));
  p_bclk_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_bit |=> !bclk_o);
  p_lr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_lr |=> $stable(lrclk_o));
  p_word_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_word |=> (!wclk_o && sdata_o == '0));

endmodule

// File: tb/tb_serial_audio_fmt.sv
module tb_serial_audio_fmt;
  localparam int NCH = 6, AW = 23, OW = 20, NFR = 20;

  logic clk = 0, rst_n = 0, tick = 0, dis_lr = 0, dis_word = 0, dis_bit = 0;
  logic [NCH*AW-1:0] lacc = '0, racc = '0;
  logic [6:0] ws = 0, we = 0, len = 0;
  wire bclk, lrclk, wclk;
  wire [NCH-1:0] sd;

  always #5 clk = ~clk;

  serial_audio_fmt dut (
    .clk(clk), .rst_n(rst_n), .bclk_tick(tick), .dis_lr(dis_lr),
    .dis_word(dis_word), .dis_bit(dis_bit), .left_acc(lacc), .right_acc(racc),
    .word_start(ws), .word_end(we), .lr_len(len),
    .bclk_o(bclk), .lrclk_o(lrclk), .wclk_o(wclk), .sdata_o(sd));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampv(int v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  function automatic int sval(int fr, int ch, int side);
    case ((fr * 7 + ch * 3 + side * 5) % 9)
      0: return 0;
      1: return 524287;
      2: return 524288;
      3: return -524288;
      4: return -524289;
      5: return 4194303;
      6: return -4194304;
      7: return (fr * 40503 + ch * 7919 + side * 104729) % 1048576 - 524288;
      default: return -(ch + 1) * 1234 - fr;
    endcase
  endfunction

  function automatic int cws(int k);
    case (k) 0: return 0; 1: return 3; 2: return 2; 3: return 5; default: return 0; endcase
  endfunction
  function automatic int cwe(int k);
    case (k) 0: return 20; 1: return 13; 2: return 30; 3: return 5; default: return 19; endcase
  endfunction
  function automatic int clen(int k);
    case (k) 0: return 24; 1: return 32; 2: return 40; 3: return 24; default: return 24; endcase
  endfunction

  task automatic apply(int fr);
    ws  = 7'(cws(fr / 4));
    we  = 7'(cwe(fr / 4));
    len = 7'(clen(fr / 4));
    for (int c = 0; c < NCH; c++) begin
      lacc[c*AW +: AW] = 23'(sval(fr, c, 0));
      racc[c*AW +: AW] = 23'(sval(fr, c, 1));
    end
  endtask

  int frame = 0, halves = 0, pos = 0, nb = 0, cyc = 0;
  int aws = 0, awe = 0, alen = 32, hws = 0, hwe = 0, hlen = 32;
  bit hside = 0;
  int word [NCH];
  int pend_l [NCH];
  int pend_r [NCH];
  logic pb, plr, pw;
  logic [NCH-1:0] psd;

  task automatic finalize();
    int expw, n;
    logic [19:0] cv;
    int expv;
    chk(pos + 1 == hlen, "R3", "half length", pos + 1, hlen);
    expw = (hwe > hws) ? hwe - hws : 0;
    chk(nb == expw, "R4,R6", "word clock width", nb, expw);
    n = (nb < OW) ? nb : OW;
    for (int c = 0; c < NCH; c++) begin
      cv = 20'(clampv(hside ? pend_r[c] : pend_l[c]));
      expv = (n == 0) ? 0 : int'(cv >> (OW - n));
      chk(word[c] == expv, "R1,R7,R8", hside ? "right word" : "left word",
          word[c], expv);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    apply(0);
    repeat (3) @(negedge clk);
    chk({bclk, lrclk, wclk, sd} == '0, "R11", "outputs in reset", {bclk, lrclk, wclk, sd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({bclk, lrclk, wclk, sd} == '0, "R11", "outputs after reset", {bclk, lrclk, wclk, sd}, 0);
    tick = 1;
    for (int c = 0; c < NCH; c++) begin
      word[c] = 0; pend_l[c] = 0; pend_r[c] = 0;
    end
    pb = bclk; plr = lrclk; pw = wclk; psd = sd;

    while (frame < NFR && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      chk(bclk != pb, "R2", "bit clock toggle", bclk, !pb);
      if (!(pb && !bclk)) begin
        chk(lrclk == plr && wclk == pw && sd == psd, "R2", "change off falling edge",
            {lrclk, wclk, sd}, {plr, pw, psd});
      end else begin
        if (lrclk != plr) begin
          if (halves > 0) finalize();
          halves++;
          pos = 0; nb = 0;
          for (int c = 0; c < NCH; c++) word[c] = 0;
          if (lrclk) begin
            aws = ws; awe = we;
            for (int c = 0; c < NCH; c++) begin
              pend_l[c] = sval(frame, c, 0);
              pend_r[c] = sval(frame, c, 1);
            end
          end else begin
            alen = len;
            frame++;
            apply(frame);
          end
          hws = aws; hwe = awe; hlen = alen; hside = lrclk;
        end else begin
          pos++;
        end
        if (wclk && !pw && halves > 1)
          chk(pos == hws, "R5,R6", "word clock rise position", pos, hws);
        if (wclk) begin
          if (nb < OW) begin
            for (int c = 0; c < NCH; c++) word[c] = (word[c] << 1) | int'(sd[c]);
          end else begin
            chk(sd == '0, "R7,R9", "data after 20 bits", sd, 0);
          end
          nb++;
        end else begin
          chk(sd == '0, "R9", "data outside window", sd, 0);
        end
      end
      pb = bclk; plr = lrclk; pw = wclk; psd = sd;
    end
    chk(frame >= NFR, "R3", "frames completed", frame, NFR);

    dis_word = 1;
    repeat (100) begin
      @(negedge clk);
      chk(!wclk && sd == '0, "R10", "word output disabled", {wclk, sd}, 0);
    end
    dis_word = 0;

    dis_lr = 1;
    @(negedge clk);
    plr = lrclk;
    repeat (200) begin
      @(negedge clk);
      chk(lrclk == plr, "R10", "left/right clock frozen", lrclk, plr);
    end
    dis_lr = 0;

    dis_bit = 1;
    @(negedge clk);
    plr = lrclk;
    repeat (60) begin
      @(negedge clk);
      chk(!bclk && lrclk == plr, "R10", "bit clock stopped", {bclk, lrclk}, {1'b0, plr});
    end
    dis_bit = 0;
    @(negedge clk);
    pb = bclk;
    @(negedge clk);
    chk(bclk != pb, "R2", "bit clock resumes", bclk, !pb);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule